// File: doc/BRIEF.md
# Single-Frame Capture Sequencer

This block decides which video frame an external frame buffer records. The image sensor provides a vertical sync level and a line-valid level, and both are asynchronous to the system clock. A host pulses a request to capture one frame. The sequencer waits for the next falling edge of vertical sync and then drives the buffer's write enable high for one whole frame. It drops write enable at the falling edge that follows.

While a request is pending or a frame is being recorded, the sequencer shows busy. When the recorded frame is complete, a done flag is set. The host reads that flag with a strobe. The read shows nothing while the block is busy, and a read taken while idle clears the flag.

The sequencer also counts the rising edges of line-valid within each frame. At every falling vertical-sync edge it makes the count of the frame that just ended visible. Pixel data does not pass through this block.

Top module: `frame_capture_ctrl`

## Requirements
- R1: A request pulse while idle sets busy at the next clock edge and arms a capture.
- R2: A request pulse while busy (armed or recording) has no effect: exactly one frame is recorded and busy falls after that single frame.
- R3: At the first detected falling vsync edge after arming, write enable rises and the done flag clears, while busy stays high.
- R4: At the next detected falling vsync edge, write enable falls, busy falls, and done is set in the same edge.
- R5: A detected falling vsync edge while idle leaves write enable low and busy and done unchanged.
- R6: Each detected rising href edge adds one to the line count. At each detected falling vsync edge, `last_lines` takes the count of the frame that just ended. The count then restarts at 0, or at 1 if an href rise is detected in that same cycle.
- R7: `done_status` is low while busy. A `done_rd` strobe while idle clears the done flag from the next edge on.
- R8: After reset, write enable, busy, done_status and last_lines are all 0.
- R9: The line count saturates at 2^LINE_W-1 and does not wrap.
- R10: vsync and href pass through a two-flop synchroniser. A change on a sync input affects the outputs at the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| vsync_in | input | 1 | Sensor vertical sync level, asynchronous |
| href_in | input | 1 | Sensor line-valid level, asynchronous |
| cap_req | input | 1 | One-cycle capture request from the host |
| done_rd | input | 1 | One-cycle read strobe for the done flag |
| wr_en | output | 1 | Frame buffer write enable |
| busy | output | 1 | High from the accepted request until the recorded frame ends |
| done_status | output | 1 | Done flag as seen by the host, forced low while busy |
| last_lines | output | LINE_W | Line count of the most recently finished frame |

## Verification
Host strobes act at the next rising edge, so busy and the cleared done flag are due one cycle after `cap_req` or `done_rd`. Sync inputs cross two flops before edge detection. Write enable, busy, done and `last_lines` therefore change at the third rising edge after a vsync or href transition. The bench reference model carries that same three-edge delay as a plain history of input samples and compares all four results at every falling clock edge. Directed checks sample the R10 latency at exactly the second and the third edge.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        CAP_IDLE    = 2'd0,
        CAP_ARMED   = 2'd1,
        CAP_WRITING = 2'd2
    } cap_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic is_busy(cap_state_e s);
        return s != CAP_IDLE;
    endfunction

endpackage

// File: rtl/fcc_sync_edge.sv
module fcc_sync_edge #(
    parameter int STAGES = fcc_pkg::SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          din,
    output fcc_pkg::edge_t ev
);
    // STAGES synchroniser flops plus one history flop for edge detection
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], din};
    end

    always_comb begin
        ev.rise = sh[STAGES-1] & ~sh[STAGES];
        ev.fall = ~sh[STAGES-1] & sh[STAGES];
    end
endmodule

// File: rtl/fcc_line_counter.sv
module fcc_line_counter #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic              frame_end,
    output logic [LINE_W-1:0] last_lines
);
    localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

    logic [LINE_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            last_lines <= '0;
        end else if (frame_end) begin
            last_lines <= cnt;
            cnt        <= line_start ? LINE_W'(1) : '0;
        end else if (line_start && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fcc_capture_fsm.sv
module fcc_capture_fsm (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic rd,
    input  logic frame_end,
    output logic wr_en,
    output logic busy,
    output logic done_status
);
    import fcc_pkg::*;

    cap_state_e state, state_nx;
    logic       done_q, done_nx;

    always_comb begin
        state_nx = state;
        done_nx  = done_q;
        unique case (state)
            CAP_IDLE: begin
                if (rd)  done_nx  = 1'b0;
                if (req) state_nx = CAP_ARMED;
            end
            CAP_ARMED: begin
                if (frame_end) begin
                    state_nx = CAP_WRITING;
                    done_nx  = 1'b0;
                end
            end
            CAP_WRITING: begin
                if (frame_end) begin
                    state_nx = CAP_IDLE;
                    done_nx  = 1'b1;
                end
            end
            default: state_nx = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= CAP_IDLE;
            done_q <= 1'b0;
        end else begin
            state  <= state_nx;
            done_q <= done_nx;
        end
    end

    assign busy        = is_busy(state);
    assign wr_en       = (state == CAP_WRITING);
    assign done_status = done_q & ~busy;
endmodule

// File: rtl/frame_capture_ctrl.sv
module frame_capture_ctrl #(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vsync_in,
    input  logic              href_in,
    input  logic              cap_req,
    input  logic              done_rd,
    output logic              wr_en,
    output logic              busy,
    output logic              done_status,
    output logic [LINE_W-1:0] last_lines
);
    import fcc_pkg::*;

    localparam int N_SYNC = 2;   // index 0: vsync, index 1: href

    logic [N_SYNC-1:0] raw_in;
    edge_t             ev [N_SYNC];
    logic              vsync_fall;
    logic              href_rise;

    assign raw_in = {href_in, vsync_in};

    for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
        fcc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw_in[g]),
            .ev  (ev[g])
        );
    end

    assign vsync_fall = ev[0].fall;
    assign href_rise  = ev[1].rise;

    fcc_capture_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req         (cap_req),
        .rd          (done_rd),
        .frame_end   (vsync_fall),
        .wr_en       (wr_en),
        .busy        (busy),
        .done_status (done_status)
    );

    fcc_line_counter #(.LINE_W(LINE_W)) u_lines (
        .clk        (clk),
        .rst        (rst),
        .line_start (href_rise),
        .frame_end  (vsync_fall),
        .last_lines (last_lines)
    );
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker #(
    parameter int LINE_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              cap_req,
    input logic              done_rd,
    input logic              wr_en,
    input logic              busy,
    input logic              done_status,
    input logic              vfall,
    input logic [LINE_W-1:0] last_lines
);
    AST_IDLE_REQ_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!busy && cap_req) |=> busy);                                   // R1
    AST_WEN_STEADY: assert property (@(posedge clk) disable iff (rst)
        !vfall |=> $stable(wr_en));                                     // R2
    AST_WEN_WITH_BUSY: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);                                                // R3
    AST_WEN_RISE_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_en) |-> $past(vfall));                                 // R3
    AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(vfall) && done_status && !wr_en));       // R4
    AST_DONE_MASKED: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done_status);                                         // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (done_status && done_rd) |=> !done_status);                     // R7
    AST_LAST_HELD: assert property (@(posedge clk) disable iff (rst)
        !vfall |=> $stable(last_lines));                                // R6
endmodule

bind frame_capture_ctrl fcc_checker #(.LINE_W(LINE_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cap_req     (cap_req),
    .done_rd     (done_rd),
    .wr_en       (wr_en),
    .busy        (busy),
    .done_status (done_status),
    .vfall       (vsync_fall),
    .last_lines  (last_lines)
);

// File: tb/sim_frame_capture_ctrl.sv
module sim_frame_capture_ctrl;
    localparam int LW    = 5;
    localparam int LMAX  = (1 << LW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vs = 1'b0, hs = 1'b0, req = 1'b0, rd = 1'b0;
    logic wr_en, busy, done_status;
    logic [LW-1:0] last_lines;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    frame_capture_ctrl #(.LINE_W(LW)) u0 (
        .clk(clk), .rst(rst), .vsync_in(vs), .href_in(hs),
        .cap_req(req), .done_rd(rd), .wr_en(wr_en), .busy(busy),
        .done_status(done_status), .last_lines(last_lines)
    );

    // reference model: sample history of the sync inputs plus plain state
    int m_v[3], m_h[3];
    int m_busy, m_pend, m_wen, m_done, m_cnt, m_last;

    always @(posedge clk) begin
        if (rst) begin
            m_v = '{0,0,0}; m_h = '{0,0,0};
            m_busy = 0; m_pend = 0; m_wen = 0; m_done = 0; m_cnt = 0; m_last = 0;
        end else begin
            int vf, hr, ob, op;
            vf = (m_v[2] == 1 && m_v[1] == 0);
            hr = (m_h[1] == 1 && m_h[2] == 0);
            ob = m_busy; op = m_pend;
            if (rd && !ob) m_done = 0;
            if (vf) begin
                if (op) begin m_wen = 1; m_done = 0; m_pend = 0; end
                else begin
                    m_wen = 0;
                    if (ob) begin m_busy = 0; m_done = 1; end
                end
            end
            if (req && !ob) begin m_busy = 1; m_pend = 1; end
            if (vf) begin m_last = m_cnt; m_cnt = hr; end
            else if (hr && m_cnt < LMAX) m_cnt = m_cnt + 1;
            m_v[2] = m_v[1]; m_v[1] = m_v[0]; m_v[0] = vs;
            m_h[2] = m_h[1]; m_h[1] = m_h[0]; m_h[0] = hs;
        end
    end

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            check("R3/R4 wr_en vs model", int'(wr_en), m_wen);
            check("R1/R2 busy vs model", int'(busy), m_busy);
            check("R7 done_status vs model", int'(done_status), (m_done && !m_busy) ? 1 : 0);
            check("R6/R9 last_lines vs model", int'(last_lines), m_last);
        end
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req();
        req = 1'b1; tick(); req = 1'b0;
    endtask

    task automatic pulse_rd();
        rd = 1'b1; tick(); rd = 1'b0;
    endtask

    // vsync high then low (frame boundary), then n line-valid pulses
    task automatic frame(int n);
        vs = 1'b1; tick(3); vs = 1'b0; tick(2);
        for (int i = 0; i < n; i++) begin
            hs = 1'b1; tick(2); hs = 1'b0; tick(2);
        end
        tick(2);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick();
        check("R8 reset wr_en", int'(wr_en), 0);
        check("R8 reset busy", int'(busy), 0);
        check("R8 reset done_status", int'(done_status), 0);
        check("R8 reset last_lines", int'(last_lines), 0);

        // idle frames: no write enable
        frame(3);
        frame(2);
        check("R5 idle fall keeps wr_en low", int'(wr_en), 0);
        check("R5 idle fall keeps busy low", int'(busy), 0);
        check("R6 last_lines after 3-line frame", int'(last_lines), 3);

        // request, extra request while busy ignored
        pulse_req();
        check("R1 busy after request", int'(busy), 1);
        pulse_req();
        pulse_rd();
        check("R7 done hidden while busy", int'(done_status), 0);
        frame(4);
        check("R3 wr_en high during frame", int'(wr_en), 1);
        pulse_req();
        frame(6);
        check("R4 wr_en low after frame", int'(wr_en), 0);
        check("R4 busy low after frame", int'(busy), 0);
        check("R4 done set", int'(done_status), 1);
        check("R6 last_lines recorded frame", int'(last_lines), 4);
        frame(1);
        check("R2 no second capture", int'(wr_en), 0);
        check("R2 done still set", int'(done_status), 1);
        pulse_rd();
        check("R7 read clears done", int'(done_status), 0);

        // saturation
        frame(40);
        frame(0);
        check("R9 saturated count", int'(last_lines), LMAX);

        // latency of the synchroniser path
        pulse_req();
        vs = 1'b1; tick(4);
        vs = 1'b0;
        tick(2);
        check("R10 wr_en still low after two edges", int'(wr_en), 0);
        tick();
        check("R10 wr_en high at third edge", int'(wr_en), 1);
        frame(2);
        frame(0);
        check("R4 second capture done", int'(done_status), 1);
        tick(4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule